// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block collects interrupt requests from a row of device slots and presents them to a processor as one shared, active-low request line. Every slot holds a pending flag and a device ID code that can be reprogrammed. When the processor raises its acknowledge input, the grant enters slot 0 and moves down the row. Each slot that has nothing pending passes the grant on. The first slot that has a request pending keeps the grant, puts its ID code on the vector output and drops its own request.

Priority comes only from position in the chain, so slot 0 always wins over higher-numbered slots. The vector output and its valid flag are qualified by the acknowledge input within the same cycle. The pending flags and ID codes are registers. Looking up the service routine from the vector is left to the processor.

Top module: `daisy_vec_ack`

## Requirements
- R1: After reset no slot is pending: `intr_n` is 1 and, with `ack` low, `vec_valid` is 0 and `vec_data` is 0.
- R2: A pulse on bit i of `req_set` makes slot i pending from the next cycle on. `intr_n` is 0 in every cycle in which at least one slot is pending and 1 otherwise.
- R3: In a cycle with `ack` high and at least one slot pending, `vec_valid` is 1 and `vec_data` equals the ID code of the pending slot with the lowest index.
- R4: The slot that wins an acknowledge stops being pending from the next cycle. All other pending slots stay pending.
- R5: In a cycle with `ack` high and no slot pending, `vec_valid` is 0 and `vec_data` is 0.
- R6: A `req_set` bit that is high in an acknowledge cycle is not granted in that cycle. Its slot is pending in the next cycle, even if that same slot won the acknowledge.
- R7: With `id_we` high, `id_wdata` is stored as the ID code of slot `id_wsel` (a binary slot index) and is used from the next cycle. The other ID codes are unchanged.
- R8: After reset the ID code of slot i is i, truncated to `ID_W` bits.
- R9: In any cycle with `ack` low, `vec_valid` is 0 and `vec_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | N_SLOTS | Per-slot request pulse, one bit per slot |
| ack | input | 1 | Processor acknowledge, enters slot 0 |
| id_we | input | 1 | ID code write enable |
| id_wsel | input | SEL_W | Index of the slot whose ID code is written |
| id_wdata | input | ID_W | New ID code |
| intr_n | output | 1 | Shared request line, active low |
| vec_valid | output | 1 | A slot won the current acknowledge |
| vec_data | output | ID_W | ID code of the winning slot, zero otherwise |

## Verification
The bound checker watches every cycle for the following:
- the vector output staying silent while `ack` is low or while `intr_n` is high;
- `intr_n` going low one cycle after any request pulse;
- the number of pending slots falling by exactly the number of winners when no new request arrives.

Some properties need the bench's reference model of the whole pending set and of the ID codes. These are which slot wins under a given request pattern, that the right ID code appears after reprogramming, the reset-time ID codes, and the rule that a request arriving during an acknowledge is held over.

// File: rtl/daisy_vec_pkg.sv
package daisy_vec_pkg;
  localparam int DEF_SLOTS = 8;
  localparam int DEF_ID_W  = 8;

  function automatic int sel_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dv_slot.sv
module dv_slot #(
  parameter int ID_W   = 8,
  parameter int RST_ID = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_req,
  input  logic            grant_in,
  input  logic            id_load,
  input  logic [ID_W-1:0] id_value,
  output logic            grant_out,
  output logic            won,
  output logic            pending,
  output logic [ID_W-1:0] code
);
  logic pend_q;
  logic [ID_W-1:0] code_q;

  // a slot keeps the grant only when it has a request of its own
  assign won       = grant_in & pend_q;
  assign grant_out = grant_in & ~pend_q;
  assign pending   = pend_q;
  assign code      = code_q;

  // a new request dominates the clear caused by winning
  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (set_req) pend_q <= 1'b1;
    else if (won)     pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)          code_q <= ID_W'(RST_ID);
    else if (id_load) code_q <= id_value;
  end
endmodule

// File: rtl/dv_vec_merge.sv
module dv_vec_merge #(
  parameter int N_SLOTS = 8,
  parameter int ID_W    = 8
) (
  input  logic [N_SLOTS-1:0]           won,
  input  logic [N_SLOTS-1:0][ID_W-1:0] codes,
  output logic                         any_won,
  output logic [ID_W-1:0]              merged
);
  // at most one slot wins, so OR-merging the gated codes acts as a select
  always_comb begin
    merged = '0;
    for (int i = 0; i < N_SLOTS; i++)
      merged |= codes[i] & {ID_W{won[i]}};
  end
  assign any_won = |won;
endmodule

// File: rtl/daisy_vec_ack.sv
module daisy_vec_ack
  import daisy_vec_pkg::*;
#(
  parameter int N_SLOTS = DEF_SLOTS,
  parameter int ID_W    = DEF_ID_W,
  localparam int SEL_W  = sel_bits(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_SLOTS-1:0] req_set,
  input  logic               ack,
  input  logic               id_we,
  input  logic [SEL_W-1:0]   id_wsel,
  input  logic [ID_W-1:0]    id_wdata,
  output logic               intr_n,
  output logic               vec_valid,
  output logic [ID_W-1:0]    vec_data
);
  logic [N_SLOTS:0]              grant_chain;
  logic [N_SLOTS-1:0]            won;
  logic [N_SLOTS-1:0]            pend;
  logic [N_SLOTS-1:0][ID_W-1:0]  codes;

  assign grant_chain[0] = ack;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    dv_slot #(.ID_W(ID_W), .RST_ID(g)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .set_req  (req_set[g]),
      .grant_in (grant_chain[g]),
      .id_load  (id_we && (id_wsel == SEL_W'(g))),
      .id_value (id_wdata),
      .grant_out(grant_chain[g+1]),
      .won      (won[g]),
      .pending  (pend[g]),
      .code     (codes[g])
    );
  end

  dv_vec_merge #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_merge (
    .won    (won),
    .codes  (codes),
    .any_won(vec_valid),
    .merged (vec_data)
  );

  assign intr_n = ~|pend;
endmodule

// File: rtl/daisy_vec_ack_chk.sv
module daisy_vec_ack_chk #(
  parameter int N_SLOTS = 8,
  parameter int ID_W    = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N_SLOTS-1:0] req_set,
  input logic               ack,
  input logic               intr_n,
  input logic               vec_valid,
  input logic [ID_W-1:0]    vec_data,
  input logic [N_SLOTS-1:0] pend
);
  // R9: no acknowledge, no vector
  a_r9_quiet_without_ack: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (!vec_valid && vec_data == '0));

  // R5: acknowledge with an idle request line yields nothing
  a_r5_empty_ack: assert property (@(posedge clk) disable iff (rst)
    (ack && intr_n) |-> (!vec_valid && vec_data == '0));

  // R3: a valid vector needs the request line active
  a_r3_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> !intr_n);

  // R2: a request pulse drives the shared line low next cycle
  a_r2_line_follows_set: assert property (@(posedge clk) disable iff (rst)
    (req_set != '0) |=> !intr_n);

  // R4: without new requests, the pending count drops by the winner count
  a_r4_one_cleared: assert property (@(posedge clk) disable iff (rst)
    (req_set == '0) |=>
      ($countones(pend) == $countones($past(pend)) - int'($past(vec_valid))));
endmodule

bind daisy_vec_ack daisy_vec_ack_chk #(.N_SLOTS(N_SLOTS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_set(req_set), .ack(ack), .intr_n(intr_n),
  .vec_valid(vec_valid), .vec_data(vec_data), .pend(pend)
);

// File: tb/daisy_vec_ack_test.sv
module daisy_vec_ack_test;
  localparam int N  = 8;
  localparam int IW = 8;
  localparam int SW = 3;
  localparam time CLK_P = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req_set;
  logic          ack;
  logic          id_we;
  logic [SW-1:0] id_wsel;
  logic [IW-1:0] id_wdata;
  logic          intr_n, vec_valid;
  logic [IW-1:0] vec_data;

  int total = 0, bad = 0;
  logic [N-1:0]  m_pend;
  logic [IW-1:0] m_id [N];

  always #(CLK_P/2) clk = ~clk;

  daisy_vec_ack #(.N_SLOTS(N), .ID_W(IW)) uut (
    .clk(clk), .rst(rst), .req_set(req_set), .ack(ack), .id_we(id_we),
    .id_wsel(id_wsel), .id_wdata(id_wdata), .intr_n(intr_n),
    .vec_valid(vec_valid), .vec_data(vec_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [N-1:0] p);
    for (int i = 0; i < N; i++) if (p[i]) return i;
    return -1;
  endfunction

  // drive one cycle at the falling edge, check, then advance the model past the rising edge
  task automatic step(input logic [N-1:0] s, input logic a, input logic we,
                      input logic [SW-1:0] sel, input logic [IW-1:0] wd);
    int w;
    @(negedge clk);
    req_set = s; ack = a; id_we = we; id_wsel = sel; id_wdata = wd;
    #1;
    w = a ? winner(m_pend) : -1;
    chk("R2 intr_n", 32'(intr_n), 32'(m_pend == '0));
    if (!a) begin
      chk("R9 valid", 32'(vec_valid), 0);
      chk("R9 data", 32'(vec_data), 0);
    end else if (w < 0) begin
      chk("R5 valid", 32'(vec_valid), 0);
      chk("R5 data", 32'(vec_data), 0);
    end else begin
      chk("R3 valid", 32'(vec_valid), 1);
      chk("R3 data", 32'(vec_data), 32'(m_id[w]));
    end
    @(posedge clk);
    // R4 winner cleared, R6 new request dominates
    if (w >= 0) m_pend[w] = 1'b0;
    m_pend = m_pend | s;
    if (we) m_id[sel] = wd;
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; req_set = '0; ack = 1'b0; id_we = 1'b0; id_wsel = '0; id_wdata = '0;
    m_pend = '0;
    for (int i = 0; i < N; i++) m_id[i] = IW'(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 intr_n", 32'(intr_n), 1);
    chk("R1 valid", 32'(vec_valid), 0);
    chk("R1 data", 32'(vec_data), 0);

    // R8: reset IDs, one slot at a time
    for (int i = 0; i < N; i++) begin
      step(N'(1) << i, 1'b0, 1'b0, '0, '0);
      step('0, 1'b1, 1'b0, '0, '0);
      chk("R8 reset id drained", 32'(m_pend), 0);
    end
    // R5: acknowledge with nothing pending
    step('0, 1'b1, 1'b0, '0, '0);
    // R3/R4: priority order among several pending slots
    step(8'b1010_0100, 1'b0, 1'b0, '0, '0);
    step('0, 1'b1, 1'b0, '0, '0);
    step('0, 1'b1, 1'b0, '0, '0);
    step('0, 1'b1, 1'b0, '0, '0);
    step('0, 1'b1, 1'b0, '0, '0);
    // R6: request during acknowledge, same slot that wins, and a higher-priority slot
    step(8'b0001_0000, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    req_set = 8'b0001_0001; ack = 1'b1; id_we = 1'b0;
    #1;
    chk("R6 not granted same cycle", 32'(vec_data), 32'(m_id[4]));
    @(posedge clk);
    m_pend = 8'b0001_0001;
    step('0, 1'b1, 1'b0, '0, '0);
    chk("R6 held pending", 32'(m_pend), 32'h10);
    step('0, 1'b1, 1'b0, '0, '0);
    // R7: program IDs, then acknowledge
    step('0, 1'b0, 1'b1, 3'd6, 8'hC3);
    step(8'b0100_0000, 1'b0, 1'b1, 3'd2, 8'h5A);
    step('0, 1'b1, 1'b0, '0, '0);
    chk("R7 id used", 32'(m_id[6]), 32'hC3);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] s;
      s = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(s, ($urandom % 3) == 0, ($urandom % 8) == 0, SW'($urandom), IW'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule